// File: doc/BRIEF.md
# BCD Clock Calendar Timekeeper

This block keeps time of day and calendar date in packed BCD: seconds, minutes, hours, day of month, month, weekday and a two-digit year. A prescaler counts enable pulses from a 32.768 kHz reference, and one second elapses each time it wraps. Each second ripples through the seconds, minutes, hours, date, month and year counters as far as the carries reach. The end of each month is worked out from the month and the year, including leap Februaries.

The hours register carries its own format select. In 24-hour mode it counts 00 to 23. In 12-hour mode it counts 12, 01 to 11, with a PM flag. A halt flag kept in the seconds register freezes both the prescaler and the counters. A host reads or writes any register by index over a parallel port. Reads are combinational. A write takes effect at the next clock edge and restarts the sub-second phase.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour mode), date 01, month 01, weekday 01, year 00, with the halt flag clear.
- R2: Seconds and minutes count in BCD from 00 to 59. A wrap from 59 to 00 advances the next counter up.
- R3: With hours bit 7 at 0, hours count 00 to 23. A wrap from 23 to 00 advances the date.
- R4: With hours bit 7 at 1, the hours field (bits 4:0) runs 12, 01, ..., 11, and bit 5 is PM. Going from 11 to 12 toggles bit 5. Only 11 PM to 12 AM advances the date. The mode bit is never changed by counting.
- R5: The date wraps to 01 and advances the month after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other non-February months. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: February ends on 29 when the BCD year is a multiple of 4, with 00 counted as one. In every other year it ends on 28.
- R7: The weekday advances with each date advance, counting 1 to 7 and wrapping from 7 to 1.
- R8: One second elapses on the DIV-th reference enable pulse after the prescaler was last cleared. Clock cycles without a pulse do not count.
- R9: While seconds bit 7 is 1, no register counts and the prescaler holds. Writing that bit to 0 restarts counting.
- R10: A host write lands at the next edge and takes priority over a second elapsing in the same cycle. That second is dropped, and the prescaler restarts from zero.
- R11: Register index map: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year. Unused bits read 0: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and weekday bits 7:3. Index 7 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | One-cycle enable per 32.768 kHz reference period |
| wr_en_i | input | 1 | Host register write strobe |
| addr_i | input | 3 | Register index for read and write |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Contents of the register at addr_i |

## Verification
The hardest situations to reach from the ports are the calendar edges: year-end rollover, the ends of 30-day months, and February in leap and common years. Counting up to them second by second would take far too many cycles. The bench preloads every register to one second before each edge through the host port. With a small divider, it then issues exactly DIV reference pulses and reads back all seven registers. The same preload method places a host write in the very cycle the prescaler would wrap, which exercises the write-over-tick priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    IDX_SEC  = 3'd0,
    IDX_MIN  = 3'd1,
    IDX_HOUR = 3'd2,
    IDX_DATE = 3'd3,
    IDX_MON  = 3'd4,
    IDX_WDAY = 3'd5,
    IDX_YEAR = 3'd6
  } reg_idx_e;

  localparam logic [7:0] MASK_SEC  = 8'hFF;
  localparam logic [7:0] MASK_MIN  = 8'h7F;
  localparam logic [7:0] MASK_HOUR = 8'hBF;
  localparam logic [7:0] MASK_DATE = 8'h3F;
  localparam logic [7:0] MASK_MON  = 8'h1F;
  localparam logic [7:0] MASK_WDAY = 8'h07;
  localparam logic [7:0] MASK_YEAR = 8'hFF;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = ref_en_i & run_i & ~clr_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (ref_en_i && run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_step_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic       sec_wrap, min_wrap, hour_wrap;
  logic       min_step, hour_step;
  logic [7:0] sec_nx, min_nx, hour_nx;

  assign sec_wrap = (sec_q[6:0] == 7'h59);
  assign min_wrap = (min_q[6:0] == 7'h59);
  assign min_step  = tick_i & sec_wrap;
  assign hour_step = min_step & min_wrap;

  assign sec_nx = sec_wrap ? {sec_q[7], 7'h00} : {sec_q[7], bcd_inc({1'b0, sec_q[6:0]})[6:0]};
  assign min_nx = min_wrap ? 8'h00 : bcd_inc({1'b0, min_q[6:0]});

  always_comb begin
    hour_nx   = hour_q;
    hour_wrap = 1'b0;
    if (hour_q[7]) begin
      // 12-hour: 12 -> 01, 11 -> 12 flips PM, 11 PM ends the day
      if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[7:5], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {hour_q[7], 1'b0, ~hour_q[5], 5'h12};
        hour_wrap = hour_q[5];
      end else begin
        hour_nx = {hour_q[7:5], bcd_inc({3'b0, hour_q[4:0]})[4:0]};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_nx   = 8'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nx = {2'b00, bcd_inc({2'b0, hour_q[5:0]})[5:0]};
      end
    end
  end

  assign day_step_o = hour_step & hour_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en_i) begin
      if (addr_i == IDX_SEC)  sec_q  <= wdata_i & MASK_SEC;
      if (addr_i == IDX_MIN)  min_q  <= wdata_i & MASK_MIN;
      if (addr_i == IDX_HOUR) hour_q <= wdata_i & MASK_HOUR;
    end else begin
      if (tick_i)    sec_q  <= sec_nx;
      if (min_step)  min_q  <= min_nx;
      if (hour_step) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_step_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  logic [7:0] date_q, mon_q, wday_q, year_q;
  logic [7:0] last_day;
  logic       date_wrap, mon_wrap, mon_step, year_step;

  assign last_day  = month_last_day(mon_q, year_q);
  assign date_wrap = (date_q == last_day);
  assign mon_wrap  = (mon_q == 8'h12);
  assign mon_step  = day_step_i & date_wrap;
  assign year_step = mon_step & mon_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      wday_q <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en_i) begin
      if (addr_i == IDX_DATE) date_q <= wdata_i & MASK_DATE;
      if (addr_i == IDX_MON)  mon_q  <= wdata_i & MASK_MON;
      if (addr_i == IDX_WDAY) wday_q <= wdata_i & MASK_WDAY;
      if (addr_i == IDX_YEAR) year_q <= wdata_i & MASK_YEAR;
    end else begin
      if (day_step_i) begin
        date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
        wday_q <= (wday_q[2:0] == 3'd7) ? 8'h01 : wday_q + 8'h01;
      end
      if (mon_step)  mon_q  <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
      if (year_step) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign wday_o = wday_q;
  assign year_o = year_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic       tick;
  logic       day_step;
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, wday_q, year_q;

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_en_i(ref_en_i),
    .run_i   (~sec_q[7]),
    .clr_i   (wr_en_i),
    .tick_o  (tick)
  );

  rtc_time_chain u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .sec_o     (sec_q),
    .min_o     (min_q),
    .hour_o    (hour_q),
    .day_step_o(day_step)
  );

  rtc_date_chain u_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .day_step_i(day_step),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .date_o    (date_q),
    .mon_o     (mon_q),
    .wday_o    (wday_q),
    .year_o    (year_q)
  );

  always_comb begin
    case (addr_i)
      IDX_SEC:  rdata_o = sec_q;
      IDX_MIN:  rdata_o = min_q;
      IDX_HOUR: rdata_o = hour_q;
      IDX_DATE: rdata_o = date_q;
      IDX_MON:  rdata_o = mon_q;
      IDX_WDAY: rdata_o = wday_q;
      IDX_YEAR: rdata_o = year_q;
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       tick,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] wday_q
);
  p_min_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && sec_q[6:0] == 7'h59 && min_q[6:0] == 7'h59 |=> min_q[6:0] == 7'h00);

  p_day_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && sec_q[6:0] == 7'h59 && min_q[6:0] == 7'h59 && hour_q == 8'h23
    |=> hour_q == 8'h00 && !$stable(date_q));

  p_mode_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> hour_q[7] == $past(hour_q[7]));

  p_wday_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wday_q) && !$past(wr_en_i) |-> wday_q == 8'h01 || wday_q == $past(wday_q) + 8'h01);

  p_halt_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q[7] && !wr_en_i |=> $stable(sec_q) && $stable(min_q) && $stable(hour_q));

  p_halt_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q[7] |-> !tick);

  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 3'd1 |=> min_q == ($past(wdata_i) & 8'h7F));

  p_idx7_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 3'd7 |-> rdata_o == 8'h00);
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .tick   (tick),
  .sec_q  (sec_q),
  .min_q  (min_q),
  .hour_q (hour_q),
  .date_q (date_q),
  .wday_q (wday_q)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
  localparam int unsigned DIV = 4;
  localparam int NVEC = 16;

  // each row: preload idx0..6, then expected idx0..6 after one second
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h59592331120799, 56'h00000001010100},  // R5 R7 year end
    {56'h56341215060321, 56'h57341215060321},  // R2
    {56'h59590915060321, 56'h00001015060321},  // R2 R3
    {56'h59591915060321, 56'h00002015060321},  // R3
    {56'h59592330040205, 56'h00000001050305},  // R5 30-day
    {56'h59592328020423, 56'h00000001030523},  // R6 common
    {56'h59592328020424, 56'h00000029020524},  // R6 leap
    {56'h59592329020524, 56'h00000001030624},  // R6
    {56'h59592328020100, 56'h00000029020200},  // R6 year 00
    {56'h5959B110030624, 56'h00009211030724},  // R4 11PM->12AM
    {56'h59599110030624, 56'h0000B210030624},  // R4 11AM->12PM
    {56'h5959B210030624, 56'h0000A110030624},  // R4 12PM->01PM
    {56'h59592330090724, 56'h00000001100124},  // R5 R7 Sep
    {56'h59592331010324, 56'h00000001020424},  // R5 Jan
    {56'h59592330010324, 56'h00000031010424},  // R5 no wrap
    {56'h59599210030624, 56'h00008110030624}   // R4 12AM->01AM
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  bcd_rtc_core #(.DIV(DIV)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_en_i(ref_en_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = idx; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = idx;
    #1 d = rdata_o;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); ref_en_i = 1'b1;
      @(negedge clk_i); ref_en_i = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [55:0] pre, exp;
    logic [7:0] rst_exp [7];
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    for (int k = 0; k < 7; k++) begin
      rd_reg(3'(k), d);
      chk("R1 reset", d, rst_exp[k]);
    end

    // vector table: preload, one second, read all
    for (int v = 0; v < NVEC; v++) begin
      pre = VEC[v][111:56];
      exp = VEC[v][55:0];
      for (int k = 0; k < 7; k++) wr_reg(3'(k), pre[55-8*k -: 8]);
      pulses(DIV);
      for (int k = 0; k < 7; k++) begin
        rd_reg(3'(k), d);
        chk($sformatf("R2-R7 vec%0d idx%0d", v, k), d, exp[55-8*k -: 8]);
      end
    end

    // R8 tick on the DIV-th pulse only
    wr_reg(3'd0, 8'h00);
    repeat (10) @(negedge clk_i);
    pulses(DIV - 1);
    rd_reg(3'd0, d); chk("R8 before wrap", d, 8'h00);
    pulses(1);
    rd_reg(3'd0, d); chk("R8 on wrap", d, 8'h01);

    // R9 halt
    wr_reg(3'd0, 8'h90);
    pulses(3 * DIV);
    rd_reg(3'd0, d); chk("R9 halted", d, 8'h90);
    wr_reg(3'd0, 8'h10);
    pulses(DIV);
    rd_reg(3'd0, d); chk("R9 restart", d, 8'h11);

    // R10 write in the wrap cycle drops that second
    wr_reg(3'd0, 8'h05);
    pulses(DIV - 1);
    @(negedge clk_i);
    ref_en_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h22;
    @(negedge clk_i);
    ref_en_i = 1'b0; wr_en_i = 1'b0;
    rd_reg(3'd0, d); chk("R10 tick dropped", d, 8'h05);
    rd_reg(3'd1, d); chk("R10 write landed", d, 8'h22);
    pulses(DIV - 1);
    rd_reg(3'd0, d); chk("R10 prescaler cleared", d, 8'h05);
    pulses(1);
    rd_reg(3'd0, d); chk("R10 next second", d, 8'h06);

    // R11 unused bits and index 7
    wr_reg(3'd1, 8'hFF); rd_reg(3'd1, d); chk("R11 min mask", d, 8'h7F);
    wr_reg(3'd2, 8'hFF); rd_reg(3'd2, d); chk("R11 hour mask", d, 8'hBF);
    wr_reg(3'd3, 8'hFF); rd_reg(3'd3, d); chk("R11 date mask", d, 8'h3F);
    wr_reg(3'd4, 8'hFF); rd_reg(3'd4, d); chk("R11 month mask", d, 8'h1F);
    wr_reg(3'd5, 8'hFF); rd_reg(3'd5, d); chk("R11 wday mask", d, 8'h07);
    wr_reg(3'd6, 8'h42);
    wr_reg(3'd7, 8'hFF); rd_reg(3'd7, d); chk("R11 idx7 zero", d, 8'h00);
    rd_reg(3'd6, d); chk("R11 idx7 write ignored", d, 8'h42);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule